// File: doc/BRIEF.md
# Conditional-Subtract Serial Divider

This block divides a 16-bit dividend by a 16-bit divisor one quotient bit per clock. A single 32-bit working register holds the dividend, the partial remainder and the growing quotient. Each step subtracts the divisor, shifted up by 15 bits, from the working register. A non-negative difference is shifted up by one with a 1 entering bit 0. A negative difference is thrown away, and the register is shifted up by one with a 0 entering bit 0. After sixteen steps the quotient is in the low half of the register and the remainder is in the high half.

A start pulse captures the operands and the mode. In signed mode the block records whether the product of the operands is negative, works on the two magnitudes, and negates the quotient at the end. The remainder is always returned as a magnitude. A zero divisor raises an error flag and returns a fixed result. The results are presented together with a one-cycle completion pulse, and they stay on the outputs until the next completion.

Top module: `cond_sub_divider`

## Requirements
- R1: While busy is low, a start sample loads the operands. Busy then reads high for the next 17 cycles: 16 step cycles and one finishing cycle.
- R2: Done is high for exactly one cycle, in the cycle after the 16th step, and in that cycle busy reads low. Done and busy are never high together.
- R3: With is_signed low, quotient equals floor(dividend / divisor) and remainder equals dividend mod divisor, both treated as unsigned 16-bit values.
- R4: With is_signed high, both operands are read as two's complement. The quotient is |dividend| / |divisor|, negated to two's complement when exactly one operand is negative. The remainder is |dividend| mod |divisor|, as an unsigned magnitude.
- R5: A zero divisor sets div_zero, in either mode. The quotient is then 0xFFFF and the remainder equals the dividend input exactly as it was given. With a non-zero divisor, div_zero is 0.
- R6: A start sample while busy is high is ignored. The division in progress finishes with its own operands and timing.
- R7: Quotient, remainder and div_zero change only in the cycle where done is high, and they hold their values until the next done.
- R8: After reset, busy, done, div_zero, quotient and remainder are all zero.
- R9: A divisor greater than the dividend (unsigned mode) gives quotient 0 and remainder equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division; sampled only while idle |
| is_signed | input | 1 | 1 treats the operands as two's complement |
| dividend | input | 16 | Dividend operand |
| divisor | input | 16 | Divisor operand |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when new results appear |
| quotient | output | 16 | Quotient of the last completed division |
| remainder | output | 16 | Remainder magnitude of the last completed division |
| div_zero | output | 1 | Last completed division had a zero divisor |

## Verification
The assertions assume that start is a clean synchronous level with no X value. They also assume that operands need to be valid only in the cycle where start is taken, so they say nothing about operand values at other times. The stimulus changes inputs only on the falling clock edge. It deliberately raises start mid-run with different operands, which exercises the ignore rule rather than breaking an assumption. The signed case where the most negative dividend is divided by -1 overflows the quotient. The bench model wraps it to 16 bits in the same way, so the stimulus may include it without any special handling.

// File: rtl/cond_sub_divider.sv
module cond_sub_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  localparam int WW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic [WW-1:0] work;
  logic [W-1:0]  dsr;
  logic [W-1:0]  dvd_raw;
  logic          neg, zero_dv, run, fin;
  logic [CW-1:0] steps;

  wire          a_neg  = is_signed & dividend[W-1];
  wire          b_neg  = is_signed & divisor[W-1];
  wire [W-1:0]  a_mag  = a_neg ? -dividend : dividend;
  wire [W-1:0]  b_mag  = b_neg ? -divisor : divisor;

  wire [WW:0]   alu    = {1'b0, work} - ({{(W+1){1'b0}}, dsr} << (W-1));
  wire [WW-1:0] nxt    = alu[WW] ? (work << 1) : ((alu[WW-1:0] << 1) | WW'(1));
  wire [W-1:0]  q_mag  = work[W-1:0];
  wire [W-1:0]  q_fix  = neg ? -q_mag : q_mag;

  assign busy = run | fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work      <= '0;
      dsr       <= '0;
      dvd_raw   <= '0;
      neg       <= 1'b0;
      zero_dv   <= 1'b0;
      run       <= 1'b0;
      fin       <= 1'b0;
      steps     <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run && !fin) begin
        if (start) begin
          work    <= {{W{1'b0}}, a_mag};
          dsr     <= b_mag;
          dvd_raw <= dividend;
          neg     <= a_neg ^ b_neg;
          zero_dv <= (divisor == '0);
          run     <= 1'b1;
          steps   <= '0;
        end
      end else if (run) begin
        work  <= nxt;
        steps <= steps + CW'(1);
        if (steps == CW'(W - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end else begin
        fin       <= 1'b0;
        done      <= 1'b1;
        quotient  <= zero_dv ? '1 : q_fix;
        remainder <= zero_dv ? dvd_raw : work[WW-1:W];
        div_zero  <= zero_dv;
      end
    end
  end
endmodule

// File: rtl/cond_sub_divider_chk.sv
module cond_sub_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_zero
);
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  a_r7_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(div_zero));
endmodule

bind cond_sub_divider cond_sub_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
);

// File: tb/cond_sub_divider_test.sv
module cond_sub_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [15:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, div_zero;
  logic [15:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cond_sub_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] a, input logic [15:0] b, input bit sg,
                       output logic [15:0] q, output logic [15:0] r, output bit z);
    int sa, sb, am, bm, qm;
    z = (b == 0);
    if (z) begin
      q = 16'hFFFF;
      r = a;
    end else if (sg) begin
      sa = int'($signed(a));
      sb = int'($signed(b));
      am = sa < 0 ? -sa : sa;
      bm = sb < 0 ? -sb : sb;
      qm = am / bm;
      q  = ((sa < 0) != (sb < 0)) ? 16'(-qm) : 16'(qm);
      r  = 16'(am % bm);
    end else begin
      q = a / b;
      r = a % b;
    end
  endtask

  task automatic run_div(input logic [15:0] a, input logic [15:0] b, input bit sg,
                         input bit disturb, input string tag);
    logic [15:0] eq, er;
    bit ez;
    model(a, b, sg, eq, er, ez);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; is_signed = sg;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R1 busy after start", int'(busy), 1);
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (disturb && i == 5) begin
        start = 1'b1; dividend = ~a; divisor = b + 16'd3; is_signed = ~sg;
      end
      check(busy === 1'b1 && done === 1'b0, "R1 busy during steps", int'(busy), 1);
    end
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R2 done pulse", int'({done, busy}), 2);
    check(quotient === eq, {tag, " quotient"}, int'(quotient), int'(eq));
    check(remainder === er, {tag, " remainder"}, int'(remainder), int'(er));
    check(div_zero === ez, "R5 div_zero flag", int'(div_zero), int'(ez));
    if (disturb) check(1'b1 && quotient === eq, "R6 start during busy ignored", int'(quotient), int'(eq));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R2 done single cycle", int'(done), 0);
    dividend = ~a; divisor = ~b;
    repeat (2) @(negedge clk);
    check(quotient === eq && remainder === er && div_zero === ez, "R7 results held",
          int'(quotient), int'(eq));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R8 reset control", int'({busy, done}), 0);
    check(quotient === 16'h0 && remainder === 16'h0 && div_zero === 1'b0,
          "R8 reset results", int'(quotient), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R8 idle after reset", int'(busy), 0);

    run_div(16'd100, 16'd7, 0, 0, "R3");
    run_div(16'd0, 16'd5, 0, 0, "R3");
    run_div(16'hFFFF, 16'd1, 0, 0, "R3");
    run_div(16'hFFFF, 16'hFFFF, 0, 0, "R3");
    run_div(16'd1, 16'd1, 0, 0, "R3");
    run_div(16'hFFFF, 16'd2, 0, 0, "R3");
    run_div(16'h8000, 16'h7FFF, 0, 0, "R3");
    run_div(16'd12, 16'd300, 0, 0, "R9");
    run_div(16'h1234, 16'hFFFF, 0, 0, "R9");
    run_div(16'd0, 16'd1, 0, 0, "R9");
    run_div(16'd1234, 16'd0, 0, 0, "R5");
    run_div(16'hFF9C, 16'd0, 1, 0, "R5");
    run_div(16'hFF9C, 16'd7, 1, 0, "R4");
    run_div(16'd100, 16'hFFF9, 1, 0, "R4");
    run_div(16'hFF9C, 16'hFFF9, 1, 0, "R4");
    run_div(16'h8000, 16'd1, 1, 0, "R4");
    run_div(16'h8000, 16'hFFFF, 1, 0, "R4");
    run_div(16'h7FFF, 16'h8000, 1, 0, "R4");
    run_div(16'd500, 16'd9, 0, 1, "R6");
    run_div(16'hFC00, 16'd33, 1, 1, "R6");
    for (int k = 0; k < 200; k++) begin
      ra = 16'($urandom);
      rb = (k % 4 == 0) ? 16'($urandom_range(0, 15)) : 16'($urandom);
      run_div(ra, rb, k[0], 0, k[0] ? "R4" : "R3");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule